// File: doc/BRIEF.md
# Host-to-Slave Parallel Mailbox Port

This block sits between an external master processor and an internal CPU. Bytes pass through it over an 8-bit bidirectional bus. The master side has an active-low chip select and a command/data select. It also has a pair of strobes whose meaning depends on a static bus-style input:

- Split style: separate read and write strobes.
- Data-strobe style: a single data strobe plus a read/not-write direction pin.

Each transfer lands in, or leaves from, one of two single-byte buffers. The inbound buffer, written by the master, keeps the command/data tag that was present when the strobe fell.

All master pins pass through two-flop synchronisers. A transfer completes on the synchronised rising edge of the strobe. An active-low status pin tells the master how the last exchange went: it drops after the master reads the outbound byte, and it rises after the master writes the inbound byte. The CPU side is a plain flag-and-byte port. The CPU acknowledges the inbound byte and loads the outbound byte.

Top module: `host_mailbox`

## Requirements
- R1: With `mode_i`=0, `rd_ni` low marks a master read and `wr_ni` low marks a master write. `ds_ni` and `rnw_i` are ignored.
- R2: With `mode_i`=1, `ds_ni` low marks an access and `rnw_i` gives the direction (1 = read, 0 = write). `rd_ni` and `wr_ni` are ignored.
- R3: `data_oe_o` is high exactly while `cs_ni` is low and a read strobe of the selected style is active. `data_o` always presents the outbound byte.
- R4: A completed master write with chip select active sets `ibf_o` and stores the byte in `ibf_data_o`. It also stores the value of `cd_i` at the strobe's falling edge in `ibf_cmd_o` (1 = command, 0 = data). All of this happens within 3 clock cycles of the strobe rising.
- R5: A change of `cd_i` while the strobe is already low does not alter the stored tag.
- R6: A completed master read with chip select active clears `obf_o`.
- R7: `sta_no` resets to 1. It goes to 0 within 3 clock cycles after a completed master read. It goes to 1 within 3 clock cycles after a completed master write.
- R8: A one-cycle pulse on `ibf_ack_i` clears `ibf_o`. A one-cycle pulse on `obf_load_i` stores `obf_data_i` as the outbound byte and sets `obf_o`.
- R9: An access whose chip select is inactive when the strobe falls changes neither flag, the stored bytes nor `sta_no`. The bus is not driven during such an access.
- R10: A CPU load in the same cycle as a master-read completion leaves `obf_o` set with the new byte. A CPU acknowledge in the same cycle as a master-write completion leaves `ibf_o` set with the new byte.
- R11: A master write while `ibf_o` is already set replaces the stored byte and tag, and `ibf_o` stays set.
- R12: After reset `ibf_o`=0, `obf_o`=0, `sta_no`=1 and, with idle pins, `data_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Bus style: 0 split strobes, 1 data strobe with direction |
| cs_ni | input | 1 | Master chip select, active low |
| cd_i | input | 1 | Master command (1) / data (0) select |
| rd_ni | input | 1 | Master read strobe, split style |
| wr_ni | input | 1 | Master write strobe, split style |
| ds_ni | input | 1 | Master data strobe, data-strobe style |
| rnw_i | input | 1 | Master direction, data-strobe style (1 read) |
| data_i | input | 8 | Bus value driven by the master |
| data_o | output | 8 | Outbound byte for the bus |
| data_oe_o | output | 1 | Bus drive enable |
| sta_no | output | 1 | Status to master, active low |
| ibf_o | output | 1 | Inbound byte waiting for the CPU |
| ibf_cmd_o | output | 1 | Tag of the inbound byte |
| ibf_data_o | output | 8 | Inbound byte |
| ibf_ack_i | input | 1 | CPU has taken the inbound byte |
| obf_load_i | input | 1 | CPU loads the outbound byte |
| obf_data_i | input | 8 | Outbound byte from the CPU |
| obf_o | output | 1 | Outbound byte not yet read by the master |

## Verification
The end of a master transfer can land in the same clock cycle as a CPU action on the same buffer. The two collisions are:

- a CPU load meeting a master read of the outbound byte;
- a CPU acknowledge meeting a master write of the inbound byte.

The bench counts the synchroniser stages from the strobe's rising edge and places the one-cycle CPU pulse exactly on the cycle in which the completion is registered. It then expects the CPU load and the new master byte to win. The status pin is checked in the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    BUS_SPLIT   = 1'b0,
    BUS_DSTROBE = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic valid;
    logic is_read;
    logic cmd;
  } xfer_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/mbx_strobe.sv
module mbx_strobe
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_mode_e     mode_i,
  input  logic          cs_n_s_i,
  input  logic          cd_s_i,
  input  logic          rd_n_s_i,
  input  logic          wr_n_s_i,
  input  logic          ds_n_s_i,
  input  logic          rnw_s_i,
  input  logic [DW-1:0] data_i,
  output xfer_t         evt_o,
  output logic [DW-1:0] wdata_o
);
  logic act, dir_rd, act_q;
  logic start, stop;
  logic lat_cs, lat_rd, lat_cd;

  always_comb begin
    if (mode_i == BUS_DSTROBE) begin
      act    = !ds_n_s_i;
      dir_rd = rnw_s_i;
    end else begin
      act    = !rd_n_s_i || !wr_n_s_i;
      dir_rd = !rd_n_s_i;
    end
  end

  assign start = act && !act_q;
  assign stop  = !act && act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      lat_cs  <= 1'b0;
      lat_rd  <= 1'b0;
      lat_cd  <= 1'b0;
      wdata_o <= '0;
    end else begin
      act_q <= act;
      // phase and select are frozen at the falling edge
      if (start) begin
        lat_cs <= !cs_n_s_i;
        lat_rd <= dir_rd;
        lat_cd <= cd_s_i;
      end
      // last sample taken while strobe still seen low
      if (act) wdata_o <= data_i;
    end
  end

  assign evt_o.valid   = stop && lat_cs;
  assign evt_o.is_read = lat_rd;
  assign evt_o.cmd     = lat_cd;

  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.valid |=> !evt_o.valid); // R4
  AST_EVT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.valid |-> $past(act)); // R9
endmodule

// File: rtl/mbx_buffers.sv
module mbx_buffers
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_t         evt_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          ibf_o,
  output logic          ibf_cmd_o,
  output logic [DW-1:0] ibf_data_o,
  output logic          obf_o,
  output logic [DW-1:0] obuf_o,
  output logic          sta_no
);
  logic wr_hit, rd_hit;

  assign wr_hit = evt_i.valid && !evt_i.is_read;
  assign rd_hit = evt_i.valid &&  evt_i.is_read;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_o      <= 1'b0;
      ibf_cmd_o  <= 1'b0;
      ibf_data_o <= '0;
    end else if (wr_hit) begin
      ibf_o      <= 1'b1;
      ibf_cmd_o  <= evt_i.cmd;
      ibf_data_o <= wdata_i;
    end else if (ack_i) begin
      ibf_o      <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_o  <= 1'b0;
      obuf_o <= '0;
    end else if (load_i) begin
      obf_o  <= 1'b1;
      obuf_o <= load_data_i;
    end else if (rd_hit) begin
      obf_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sta_no <= 1'b1;
    else if (wr_hit) sta_no <= 1'b1;
    else if (rd_hit) sta_no <= 1'b0;
  end

  AST_IBF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(ibf_data_o)); // R4
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> obf_o); // R10
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> ibf_o); // R11
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          cd_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          ds_ni,
  input  logic          rnw_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          sta_no,
  output logic          ibf_o,
  output logic          ibf_cmd_o,
  output logic [DW-1:0] ibf_data_o,
  input  logic          ibf_ack_i,
  input  logic          obf_load_i,
  input  logic [DW-1:0] obf_data_i,
  output logic          obf_o
);
  localparam int unsigned NCTL = 6;
  localparam logic [NCTL-1:0] CTL_IDLE = 6'b101110;

  bus_mode_e     mode;
  logic [NCTL-1:0] ctl_s;
  xfer_t         evt;
  logic [DW-1:0] wdata;
  logic          rd_pin;

  assign mode = bus_mode_e'(mode_i);

  mbx_sync #(.W(NCTL), .RST_VAL(CTL_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, cd_i, rd_ni, wr_ni, ds_ni, rnw_i}),
    .q_o    (ctl_s)
  );

  mbx_strobe #(.DW(DW)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .cs_n_s_i (ctl_s[5]),
    .cd_s_i   (ctl_s[4]),
    .rd_n_s_i (ctl_s[3]),
    .wr_n_s_i (ctl_s[2]),
    .ds_n_s_i (ctl_s[1]),
    .rnw_s_i  (ctl_s[0]),
    .data_i   (data_i),
    .evt_o    (evt),
    .wdata_o  (wdata)
  );

  mbx_buffers #(.DW(DW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .wdata_i     (wdata),
    .ack_i       (ibf_ack_i),
    .load_i      (obf_load_i),
    .load_data_i (obf_data_i),
    .ibf_o       (ibf_o),
    .ibf_cmd_o   (ibf_cmd_o),
    .ibf_data_o  (ibf_data_o),
    .obf_o       (obf_o),
    .obuf_o      (data_o),
    .sta_no      (sta_no)
  );

  // bus drive follows the raw pins, no clock in the path
  assign rd_pin    = (mode == BUS_DSTROBE) ? (!ds_ni && rnw_i) : !rd_ni;
  assign data_oe_o = !cs_ni && rd_pin;

  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o); // R9
  AST_IBF_SET_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_o) |-> $past(evt.valid && !evt.is_read)); // R4
  AST_IBF_CLR_BY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ibf_o) |-> $past(ibf_ack_i)); // R8
  AST_OBF_SET_BY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(obf_o) |-> $past(obf_load_i)); // R8
  AST_OBF_CLR_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(obf_o) |-> $past(evt.valid && evt.is_read)); // R6
  AST_STA_FALL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sta_no) |-> $past(evt.valid && evt.is_read)); // R7
  AST_STA_RISE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sta_no) |-> $past(evt.valid && !evt.is_read)); // R7
endmodule

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b0, cs_ni = 1'b1, cd_i = 1'b0;
  logic       rd_ni = 1'b1, wr_ni = 1'b1, ds_ni = 1'b1, rnw_i = 1'b0;
  logic [7:0] data_i = '0, data_o, ibf_data_o, obf_data_i = '0;
  logic       data_oe_o, sta_no, ibf_o, ibf_cmd_o, obf_o;
  logic       ibf_ack_i = 1'b0, obf_load_i = 1'b0;

  int errors = 0;
  int checks = 0;
  logic       bus_oe;
  logic [7:0] bus_val;

  always #4 clk = ~clk;

  host_mailbox u_host_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .cs_ni(cs_ni), .cd_i(cd_i),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .ds_ni(ds_ni), .rnw_i(rnw_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .sta_no(sta_no),
    .ibf_o(ibf_o), .ibf_cmd_o(ibf_cmd_o), .ibf_data_o(ibf_data_o),
    .ibf_ack_i(ibf_ack_i), .obf_load_i(obf_load_i), .obf_data_i(obf_data_i),
    .obf_o(obf_o)
  );

  // {mode, is_read, cs_on, cd, byte, flag, sta}
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h99, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h42, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'hE7, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_ack();
    @(negedge clk); ibf_ack_i = 1'b1;
    @(negedge clk); ibf_ack_i = 1'b0;
  endtask

  task automatic cpu_load(input logic [7:0] d);
    @(negedge clk); obf_load_i = 1'b1; obf_data_i = d;
    @(negedge clk); obf_load_i = 1'b0;
  endtask

  // set up pins and drop the strobe; held low 4 cycles, bus sampled while low
  task automatic strobe_low(input logic m, input logic rd, input logic cs_on,
                            input logic cd, input logic [7:0] d);
    @(negedge clk);
    mode_i = m; cs_ni = !cs_on; cd_i = cd; rnw_i = rd; data_i = rd ? 8'h00 : d;
    @(negedge clk);
    if (m) ds_ni = 1'b0;
    else if (rd) rd_ni = 1'b0;
    else wr_ni = 1'b0;
    repeat (3) @(negedge clk);
    bus_oe = data_oe_o; bus_val = data_o;
    @(negedge clk);
  endtask

  task automatic strobe_high();
    rd_ni = 1'b1; wr_ni = 1'b1; ds_ni = 1'b1;
  endtask

  task automatic finish_xfer();
    repeat (3) @(negedge clk);
    cs_ni = 1'b1; rnw_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic m, input logic rd, input logic cs_on,
                      input logic cd, input logic [7:0] d);
    strobe_low(m, rd, cs_on, cd, d);
    strobe_high();
    finish_xfer();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk("R12 ibf", ibf_o, 0);
    chk("R12 obf", obf_o, 0);
    chk("R12 sta", sta_no, 1);
    chk("R12 oe", data_oe_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic m, rd, cs_on, cd, flag, sta;
      logic [7:0] d;
      {m, rd, cs_on, cd, d, flag, sta} = VEC[i];
      if (rd) cpu_load(d); else cpu_ack();
      xfer(m, rd, cs_on, cd, d);
      if (rd) begin
        chk(m ? "R2 R6 obf" : "R1 R6 obf", obf_o, flag);
        chk("R3 R9 oe", bus_oe, cs_on);
        if (cs_on) chk("R3 bus", bus_val, d);
      end else begin
        chk(m ? "R2 R4 ibf" : "R1 R4 ibf", ibf_o, flag);
        if (flag) begin
          chk("R4 byte", ibf_data_o, d);
          chk("R4 tag", ibf_cmd_o, cd);
        end
      end
      chk(cs_on ? "R7 sta" : "R9 sta", sta_no, sta);
    end

    // R8 acknowledge clears inbound flag
    cpu_ack();
    @(negedge clk);
    chk("R8 ack", ibf_o, 0);

    // R1 split style ignores data strobe
    @(negedge clk); mode_i = 1'b0; cs_ni = 1'b0; rnw_i = 1'b0; data_i = 8'h6D;
    @(negedge clk); ds_ni = 1'b0;
    repeat (4) @(negedge clk); ds_ni = 1'b1;
    finish_xfer();
    chk("R1 ds ignored", ibf_o, 0);

    // R5 tag frozen at strobe fall
    @(negedge clk); mode_i = 1'b0; cs_ni = 1'b0; cd_i = 1'b1; data_i = 8'h2B;
    @(negedge clk); wr_ni = 1'b0;
    repeat (3) @(negedge clk); cd_i = 1'b0;
    repeat (3) @(negedge clk); wr_ni = 1'b1;
    finish_xfer();
    chk("R5 tag", ibf_cmd_o, 1);
    chk("R5 byte", ibf_data_o, 8'h2B);

    // R11 overwrite while full
    xfer(1'b1, 1'b0, 1'b1, 1'b0, 8'hD4);
    chk("R11 ibf", ibf_o, 1);
    chk("R11 byte", ibf_data_o, 8'hD4);
    chk("R11 tag", ibf_cmd_o, 0);

    // R10 CPU load on the cycle a master read completes
    cpu_load(8'h10);
    strobe_low(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    strobe_high();
    @(posedge clk); @(posedge clk);
    @(negedge clk); obf_load_i = 1'b1; obf_data_i = 8'hB7;
    @(posedge clk); #2;
    chk("R10 load wins", obf_o, 1);
    chk("R10 new byte", data_o, 8'hB7);
    chk("R7 sta low in 3", sta_no, 0);
    @(negedge clk); obf_load_i = 1'b0;
    finish_xfer();

    // R10 CPU ack on the cycle a master write completes (ibf already full)
    strobe_low(1'b1, 1'b0, 1'b1, 1'b1, 8'h5E);
    strobe_high();
    @(posedge clk); @(posedge clk);
    @(negedge clk); ibf_ack_i = 1'b1;
    @(posedge clk); #2;
    chk("R10 write wins", ibf_o, 1);
    chk("R10 write byte", ibf_data_o, 8'h5E);
    chk("R7 sta high in 3", sta_no, 1);
    @(negedge clk); ibf_ack_i = 1'b0;
    finish_xfer();

    // R2 data-strobe style ignores split strobes
    cpu_ack();
    @(negedge clk); mode_i = 1'b1; cs_ni = 1'b0; data_i = 8'h33;
    @(negedge clk); wr_ni = 1'b0;
    repeat (4) @(negedge clk); wr_ni = 1'b1;
    finish_xfer();
    chk("R2 wr ignored", ibf_o, 0);
    chk("R2 sta kept", sta_no, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule